// File: doc/BRIEF.md
# Address Latch Stepper

This block holds a 16-bit address in a latch and computes, in the same cycle, the next address one step up or one step down from it. A CPU core loads the latch from its internal register bus. It then reads the stepped value back onto that bus, for example to write an updated program counter. It can also drive the address pins from either the stepped value or the raw latch.

The step is suppressed whenever the core is halted, acknowledging a maskable interrupt, or acknowledging a non-maskable interrupt. While any of these holds, the stepped value equals the latch. A narrow mode confines the step to the low six bits, so the upper ten bits stay as they are.

The direction decode works as a four-state selector on `step_mode`:
- IDLE (00): no step.
- UP (01): increment.
- DOWN (10): decrement.
- OPCODE (11): `opc_dir_bit` picks the direction.

The transition from a selected state to "no step" is forced by any hold input.

Top module: `addr_step_unit`

## Requirements
- R1: While reset is low the latch is 0x0000, so with `pin_sel_step`=0 the address pins read 0x0000.
- R2: On a rising clock edge with `latch_we`=1 the latch takes `bus_in`; with `latch_we`=0 it keeps its value.
- R3: With `step_mode`=01 (UP), no hold and `narrow_en`=0, the stepped value is latch+1 modulo 65536 (0xFFFF steps to 0x0000).
- R4: With `step_mode`=10 (DOWN), no hold and `narrow_en`=0, the stepped value is latch-1 modulo 65536 (0x0000 steps to 0xFFFF).
- R5: With `step_mode`=11 (OPCODE), `opc_dir_bit`=1 decrements and `opc_dir_bit`=0 increments.
- R6: With `step_mode`=00 (IDLE) the stepped value equals the latch.
- R7: If any of `halted`, `intr_ack` or `nmi_ack` is 1, the stepped value equals the latch whatever the mode.
- R8: With `narrow_en`=1, bits 15:6 of the stepped value equal the latch's bits 15:6, and bits 5:0 step modulo 64.
- R9: `bus_out` carries the stepped value when `bus_drive` is 1 and is 0x0000 otherwise; `bus_out_en` equals `bus_drive`.
- R10: `addr_pins` shows the stepped value when `pin_sel_step`=1 and the latch when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 16 | Register bus value to load into the latch |
| latch_we | input | 1 | Load the latch on the next rising edge |
| step_mode | input | 2 | 00 IDLE, 01 UP, 10 DOWN, 11 OPCODE |
| opc_dir_bit | input | 1 | Direction in OPCODE mode: 1 down, 0 up |
| narrow_en | input | 1 | Confine stepping to bits 5:0 |
| halted | input | 1 | Core halted: suppress the step |
| intr_ack | input | 1 | Maskable interrupt acknowledge: suppress the step |
| nmi_ack | input | 1 | Non-maskable interrupt acknowledge: suppress the step |
| bus_drive | input | 1 | Put the stepped value on the register bus |
| pin_sel_step | input | 1 | Address pin source: 1 stepped value, 0 latch |
| bus_out | output | 16 | Stepped value toward the register bus, or zero |
| bus_out_en | output | 1 | Register bus drive enable |
| addr_pins | output | 16 | Address pin value |

## Verification
The latch is the only state in the block. A wrong latch value therefore appears at `addr_pins` in the first cycle after the faulty edge, provided the pin source selects the latch; through the stepped value it also appears on `bus_out`. A wrong stepper decode needs no clock edge at all: it changes `bus_out` and the stepped pin value in the same cycle. For this reason the bench compares every output on every cycle against its own arithmetic model, including the wrap points at 0x0000, 0xFFFF and the six-bit boundary.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;

    typedef enum logic [1:0] {
        STEP_IDLE   = 2'b00,
        STEP_UP     = 2'b01,
        STEP_DOWN   = 2'b10,
        STEP_OPCODE = 2'b11
    } step_mode_e;

endpackage

// File: rtl/addr_hold_latch.sv
module addr_hold_latch #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
    import addr_step_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int NARROW_W = 6
) (
    input  logic [WIDTH-1:0] base,
    input  logic [1:0]       mode,
    input  logic             opc_dir,
    input  logic             narrow,
    input  logic             hold,
    output logic [WIDTH-1:0] result
);

    localparam int UPPER_W = WIDTH - NARROW_W;

    step_mode_e  mode_e;
    logic        dir_down;
    logic        active;
    logic        carry_in;
    logic [WIDTH-1:0]    full_step;
    logic [NARROW_W-1:0] low_step;

    always_comb begin
        mode_e   = step_mode_e'(mode);
        dir_down = 1'b0;
        active   = 1'b0;
        unique case (mode_e)
            STEP_IDLE:   begin active = 1'b0; dir_down = 1'b0;    end
            STEP_UP:     begin active = 1'b1; dir_down = 1'b0;    end
            STEP_DOWN:   begin active = 1'b1; dir_down = 1'b1;    end
            STEP_OPCODE: begin active = 1'b1; dir_down = opc_dir; end
        endcase
        carry_in = active & ~hold;
    end

    always_comb begin
        if (dir_down) begin
            full_step = base - {{(WIDTH-1){1'b0}}, carry_in};
            low_step  = base[NARROW_W-1:0] - {{(NARROW_W-1){1'b0}}, carry_in};
        end else begin
            full_step = base + {{(WIDTH-1){1'b0}}, carry_in};
            low_step  = base[NARROW_W-1:0] + {{(NARROW_W-1){1'b0}}, carry_in};
        end
    end

    generate
        if (UPPER_W > 0) begin : g_split
            assign result = narrow ? {base[WIDTH-1:NARROW_W], low_step} : full_step;
        end else begin : g_whole
            assign result = full_step;
        end
    endgenerate

endmodule

// File: rtl/addr_pin_mux.sv
module addr_pin_mux #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] step_val,
    input  logic [WIDTH-1:0] latch_val,
    input  logic             sel_step,
    input  logic             drive,
    output logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] bus_val,
    output logic             bus_en
);

    always_comb begin
        pins    = sel_step ? step_val : latch_val;
        bus_val = drive ? step_val : '0;
        bus_en  = drive;
    end

endmodule

// File: rtl/addr_step_unit.sv
module addr_step_unit #(
    parameter int ADDR_W   = 16,
    parameter int NARROW_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_in,
    input  logic              latch_we,
    input  logic [1:0]        step_mode,
    input  logic              opc_dir_bit,
    input  logic              narrow_en,
    input  logic              halted,
    input  logic              intr_ack,
    input  logic              nmi_ack,
    input  logic              bus_drive,
    input  logic              pin_sel_step,
    output logic [ADDR_W-1:0] bus_out,
    output logic              bus_out_en,
    output logic [ADDR_W-1:0] addr_pins
);

    logic [ADDR_W-1:0] latch_q;
    logic [ADDR_W-1:0] step_res;
    logic              hold_any;

    assign hold_any = halted | intr_ack | nmi_ack;

    addr_hold_latch #(.WIDTH(ADDR_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (latch_we),
        .d     (bus_in),
        .q     (latch_q)
    );

    addr_stepper #(.WIDTH(ADDR_W), .NARROW_W(NARROW_W)) u_stepper (
        .base    (latch_q),
        .mode    (step_mode),
        .opc_dir (opc_dir_bit),
        .narrow  (narrow_en),
        .hold    (hold_any),
        .result  (step_res)
    );

    addr_pin_mux #(.WIDTH(ADDR_W)) u_mux (
        .step_val  (step_res),
        .latch_val (latch_q),
        .sel_step  (pin_sel_step),
        .drive     (bus_drive),
        .pins      (addr_pins),
        .bus_val   (bus_out),
        .bus_en    (bus_out_en)
    );

endmodule

// File: rtl/addr_step_unit_chk.sv
module addr_step_unit_chk #(
    parameter int ADDR_W   = 16,
    parameter int NARROW_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_in,
    input logic              latch_we,
    input logic [1:0]        step_mode,
    input logic              narrow_en,
    input logic              halted,
    input logic              intr_ack,
    input logic              nmi_ack,
    input logic              bus_drive,
    input logic              pin_sel_step,
    input logic [ADDR_W-1:0] bus_out,
    input logic [ADDR_W-1:0] addr_pins,
    input logic [ADDR_W-1:0] latch_q,
    input logic [ADDR_W-1:0] step_res
);

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_we |=> latch_q == $past(bus_in));

    // R2
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_we |=> $stable(latch_q));

    // R6
    idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_mode == 2'b00 |-> step_res == latch_q);

    // R7
    hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || intr_ack || nmi_ack) |-> step_res == latch_q);

    // R8
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_en |-> step_res[ADDR_W-1:NARROW_W] == latch_q[ADDR_W-1:NARROW_W]);

    // R9
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive |-> bus_out == '0);

    // R10
    pin_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sel_step |-> addr_pins == latch_q);

    // R10
    pin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel_step && bus_drive) |-> addr_pins == bus_out);

endmodule

bind addr_step_unit addr_step_unit_chk #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_in       (bus_in),
    .latch_we     (latch_we),
    .step_mode    (step_mode),
    .narrow_en    (narrow_en),
    .halted       (halted),
    .intr_ack     (intr_ack),
    .nmi_ack      (nmi_ack),
    .bus_drive    (bus_drive),
    .pin_sel_step (pin_sel_step),
    .bus_out      (bus_out),
    .addr_pins    (addr_pins),
    .latch_q      (latch_q),
    .step_res     (step_res)
);

// File: tb/addr_step_unit_bench.sv
module addr_step_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_in = '0;
    logic        latch_we = 1'b0;
    logic [1:0]  step_mode = 2'b00;
    logic        opc_dir_bit = 1'b0;
    logic        narrow_en = 1'b0;
    logic        halted = 1'b0;
    logic        intr_ack = 1'b0;
    logic        nmi_ack = 1'b0;
    logic        bus_drive = 1'b0;
    logic        pin_sel_step = 1'b0;
    logic [15:0] bus_out;
    logic        bus_out_en;
    logic [15:0] addr_pins;

    int n_cmp = 0;
    int n_bad = 0;
    int model_latch = 0;

    always #4 clk = ~clk;

    addr_step_unit u_addr_step_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_in       (bus_in),
        .latch_we     (latch_we),
        .step_mode    (step_mode),
        .opc_dir_bit  (opc_dir_bit),
        .narrow_en    (narrow_en),
        .halted       (halted),
        .intr_ack     (intr_ack),
        .nmi_ack      (nmi_ack),
        .bus_drive    (bus_drive),
        .pin_sel_step (pin_sel_step),
        .bus_out      (bus_out),
        .bus_out_en   (bus_out_en),
        .addr_pins    (addr_pins)
    );

    function automatic int model_step(int v);
        int delta;
        if (halted || intr_ack || nmi_ack) return v;
        case (step_mode)
            2'b01: delta = 1;
            2'b10: delta = -1;
            2'b11: delta = opc_dir_bit ? -1 : 1;
            default: delta = 0;
        endcase
        if (narrow_en)
            return (v / 64) * 64 + ((v % 64) + 64 + delta) % 64;
        return (v + 65536 + delta) % 65536;
    endfunction

    task automatic compare(string tag);
        int st;
        int exp_pins;
        int exp_bus;
        st       = model_step(model_latch);
        exp_pins = pin_sel_step ? st : model_latch;
        exp_bus  = bus_drive ? st : 0;
        n_cmp++;
        if (int'(addr_pins) != exp_pins || int'(bus_out) != exp_bus || bus_out_en != bus_drive) begin
            n_bad++;
            $display("FAIL %s: pins=%h bus=%h en=%b expected pins=%h bus=%h en=%b",
                     tag, addr_pins, bus_out, bus_out_en, exp_pins[15:0], exp_bus[15:0], bus_drive);
        end
    endtask

    task automatic cyc(input logic we, input logic [15:0] d, input logic [1:0] md,
                       input logic ob, input logic nr, input logic h, input logic ia,
                       input logic na, input logic dr, input logic ps, input string tag);
        @(negedge clk);
        latch_we = we; bus_in = d; step_mode = md; opc_dir_bit = ob; narrow_en = nr;
        halted = h; intr_ack = ia; nmi_ack = na; bus_drive = dr; pin_sel_step = ps;
        #1;
        compare(tag);
        @(posedge clk);
        if (rst_n && we) model_latch = int'(d);
    endtask

    task automatic load(input logic [15:0] d);
        cyc(1'b1, d, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 load");
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, latch reads 0 on the pins
        cyc(1'b1, 16'hABCD, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 reset");
        cyc(1'b0, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R1 reset step");
        @(negedge clk);
        rst_n = 1'b1;

        load(16'h1234);
        // R2: latch keeps its value without write enable
        cyc(1'b0, 16'hFFFF, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 keep");
        // R6: idle gives latch
        cyc(1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6 idle");
        // R3: increment
        cyc(1'b0, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 up");
        load(16'hFFFF);
        cyc(1'b0, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 wrap");
        // R4: decrement
        load(16'h0000);
        cyc(1'b0, 16'h0000, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 wrap");
        load(16'h8000);
        cyc(1'b0, 16'h0000, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 down");
        // R5: opcode-selected direction
        cyc(1'b0, 16'h0000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 bit=1");
        cyc(1'b0, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 bit=0");
        // R7: each hold source suppresses the step
        cyc(1'b0, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R7 halted");
        cyc(1'b0, 16'h0000, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 intr");
        cyc(1'b0, 16'h0000, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R7 nmi");
        // R8: narrow stepping wraps in six bits
        load(16'h12BF);
        cyc(1'b0, 16'h0000, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8 up wrap");
        load(16'h1240);
        cyc(1'b0, 16'h0000, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8 down wrap");
        cyc(1'b0, 16'h0000, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8 opc up");
        // R9: bus drive off gives zero
        cyc(1'b0, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 off");
        cyc(1'b0, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 on");
        // R10: pin source select
        cyc(1'b0, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10 latch");
        cyc(1'b0, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R10 step");

        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] & r[1], r[31:16], r[3:2], r[4], r[5], r[6] & r[7] & r[8],
                r[9] & r[10] & r[11], r[12] & r[13] & r[14], r[15], r[1] ^ r[5], "mix");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule